// File: doc/BRIEF.md
# Dual-Bus GPIO Port Register File

This block holds the drive state for one or more 32-bit general-purpose I/O ports. For each port it keeps an output-enable word and an output-value word, and it drives these straight from flops onto per-pin enable and value lines. It also presents the sampled pin levels as a read-only word. Each writable word has four write-only addresses. One replaces the whole word. The other three set, clear or toggle only the bits whose data bit is 1. Software can therefore change single pins in one access, with no read-modify-write.

Two independent register ports reach the same single copy of this state. One is a general peripheral bus. The other is a CPU-local bus that takes one access on every clock cycle with no wait states. Both use the same simple single-cycle interface: valid, write, address and data. A read returns its data on the following cycle. When both buses change the same word in one cycle, the peripheral operation is applied first and the local operation second.

Top module: `gpio_dual_bus`

## Requirements
- R1: While reset is high and on the first cycle after it, pin_oe, pin_out, pb_rdata and lb_rdata are all zero.
- R2: Port p occupies addresses p*0x100 + offset. The offsets are: output-enable word at 0x40/0x44/0x48/0x4C, output-value word at 0x50/0x54/0x58/0x5C, and pin word at 0x60. Port p maps to bits [p*32 +: 32] of pin_in, pin_oe and pin_out.
- R3: Address bits [3:2] select the operation on a writable word: 0 replace, 1 set, 2 clear, 3 toggle. A replace loads the write data into the word.
- R4: Set ORs the data into the word, clear removes the data bits from it, and toggle inverts the data bits. Bits whose data bit is 0 keep their value.
- R5: A write accepted at a clock edge is visible on pin_oe/pin_out right after that edge. With no write on either bus, both outputs hold their value.
- R6: A read of offset 0x60 returns the port's pin levels on the cycle after the request. A level applied to pin_in is returned by reads issued two or more cycles later. Reads issued in the same cycle as the change or the cycle after it return the old level.
- R7: rdata is zero on the cycle after any read of a write-only offset, an unmapped address or a nonexistent port. It is also zero on the cycle after any cycle without a read on that bus.
- R8: Writes to offset 0x60, to offsets outside the map, to addresses with bits [1:0] nonzero, or to a port index of NUM_PORTS or more change no state.
- R9: When both buses write the same word in one cycle, the peripheral operation is applied first and the local operation is applied to its result, so the local bus wins on conflicting bits.
- R10: Both buses perform every operation identically. Writes from the two buses to different words in the same cycle both take effect.
- R11: The local bus accepts an access on every cycle. Back-to-back writes each take effect in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pb_valid | input | 1 | Peripheral bus access strobe |
| pb_write | input | 1 | Peripheral bus write (1) or read (0) |
| pb_addr | input | ADDR_W | Peripheral bus byte address |
| pb_wdata | input | PORT_W | Peripheral bus write data |
| pb_rdata | output | PORT_W | Peripheral bus read data, one cycle after request |
| lb_valid | input | 1 | Local bus access strobe |
| lb_write | input | 1 | Local bus write (1) or read (0) |
| lb_addr | input | ADDR_W | Local bus byte address |
| lb_wdata | input | PORT_W | Local bus write data |
| lb_rdata | output | PORT_W | Local bus read data, one cycle after request |
| pin_in | input | NUM_PORTS*PORT_W | Pin levels, asynchronous |
| pin_oe | output | NUM_PORTS*PORT_W | Per-pin drive enable |
| pin_out | output | NUM_PORTS*PORT_W | Per-pin drive value |

## Verification
The assertions assume that the bus inputs are stable around the rising edge and that an access lasts exactly one cycle whenever valid is high. The bit-level properties watch port 0 only. They take as given that the other bus is not writing in the same cycle, except for the conflict property, which requires both buses to hit the same replace address. The stimulus drives every input at the falling edge. The random addresses include same-word collisions, nonexistent ports and unaligned offsets, so the conflict and ignore cases arise often.

// File: rtl/gpio_dual_pkg.sv
package gpio_dual_pkg;

   localparam int MAX_W = 32;

   typedef enum logic [1:0] {
      OP_LOAD   = 2'd0,
      OP_SET    = 2'd1,
      OP_CLEAR  = 2'd2,
      OP_TOGGLE = 2'd3
   } gpio_op_e;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_OE   = 2'd1,
      SEL_OUT  = 2'd2,
      SEL_PIN  = 2'd3
   } gpio_sel_e;

   // One bit-wise update of a drive word
   function automatic logic [MAX_W-1:0] gpio_apply(
      input gpio_op_e         op,
      input logic [MAX_W-1:0] cur,
      input logic [MAX_W-1:0] d
   );
      logic [MAX_W-1:0] r;
      unique case (op)
         OP_LOAD:   r = d;
         OP_SET:    r = cur | d;
         OP_CLEAR:  r = cur & ~d;
         OP_TOGGLE: r = cur ^ d;
         default:   r = cur;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
   import gpio_dual_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int NUM_PORTS = 2
) (
   input  logic                 valid,
   input  logic                 write,
   input  logic [ADDR_W-1:0]    addr,
   output logic [NUM_PORTS-1:0] port_hit,
   output gpio_sel_e            sel,
   output gpio_op_e             op,
   output logic                 wr_en,
   output logic                 rd_en
);
   localparam int PIDX_W = ADDR_W - 8;

   logic [PIDX_W-1:0] pidx;

   assign pidx  = addr[ADDR_W-1:8];
   assign op    = gpio_op_e'(addr[3:2]);
   assign wr_en = valid & write;
   assign rd_en = valid & ~write;

   always_comb begin
      sel = SEL_NONE;
      unique case (addr[7:4])
         4'h4:    sel = SEL_OE;
         4'h5:    sel = SEL_OUT;
         4'h6:    if (addr[3:2] == 2'b00) sel = SEL_PIN;
         default: sel = SEL_NONE;
      endcase
      if (addr[1:0] != 2'b00) sel = SEL_NONE;
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_hit
      assign port_hit[p] = valid && (pidx == PIDX_W'(p)) && (sel != SEL_NONE);
   end

endmodule

// File: rtl/gpio_port_reg.sv
module gpio_port_reg
   import gpio_dual_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         pb_en,
   input  gpio_op_e     pb_op,
   input  logic [W-1:0] pb_data,
   input  logic         lb_en,
   input  gpio_op_e     lb_op,
   input  logic [W-1:0] lb_data,
   output logic [W-1:0] q
);
   logic [W-1:0] after_pb;
   logic [W-1:0] after_lb;

   // peripheral bus first, local bus on top of its result
   always_comb begin
      after_pb = q;
      if (pb_en) after_pb = W'(gpio_apply(pb_op, MAX_W'(q), MAX_W'(pb_data)));
      after_lb = after_pb;
      if (lb_en) after_lb = W'(gpio_apply(lb_op, MAX_W'(after_pb), MAX_W'(lb_data)));
   end

   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= after_lb;
   end

endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
         if (rst) q <= '0;
         else     q <= d;
      end
   end else begin : g_chain
      logic [W-1:0] st [STAGES];
      always_ff @(posedge clk) begin
         if (rst) begin
            for (int i = 0; i < STAGES; i++) st[i] <= '0;
         end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
         end
      end
      assign q = st[STAGES-1];
   end

endmodule

// File: rtl/gpio_read_port.sv
module gpio_read_port
   import gpio_dual_pkg::*;
#(
   parameter int NUM_PORTS = 2,
   parameter int W         = 32
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   rd_en,
   input  logic [NUM_PORTS-1:0]   port_hit,
   input  gpio_sel_e              sel,
   input  logic [NUM_PORTS*W-1:0] pin_vals,
   output logic [W-1:0]           rdata
);
   logic [W-1:0] nxt;

   always_comb begin
      nxt = '0;
      if (rd_en && sel == SEL_PIN) begin
         for (int p = 0; p < NUM_PORTS; p++) begin
            if (port_hit[p]) nxt = pin_vals[p*W +: W];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) rdata <= '0;
      else     rdata <= nxt;
   end

endmodule

// File: rtl/gpio_dual_bus.sv
module gpio_dual_bus
   import gpio_dual_pkg::*;
#(
   parameter int NUM_PORTS   = 2,
   parameter int PORT_W      = 32,
   parameter int ADDR_W      = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        pb_valid,
   input  logic                        pb_write,
   input  logic [ADDR_W-1:0]           pb_addr,
   input  logic [PORT_W-1:0]           pb_wdata,
   output logic [PORT_W-1:0]           pb_rdata,
   input  logic                        lb_valid,
   input  logic                        lb_write,
   input  logic [ADDR_W-1:0]           lb_addr,
   input  logic [PORT_W-1:0]           lb_wdata,
   output logic [PORT_W-1:0]           lb_rdata,
   input  logic [NUM_PORTS*PORT_W-1:0] pin_in,
   output logic [NUM_PORTS*PORT_W-1:0] pin_oe,
   output logic [NUM_PORTS*PORT_W-1:0] pin_out
);
   localparam int TOTAL_W   = NUM_PORTS * PORT_W;
   localparam int MAX_PORTS = 1 << (ADDR_W - 8);

   if (PORT_W < 1 || PORT_W > MAX_W) begin : g_bad_width
      $error("PORT_W must lie in 1..32");
   end
   if (ADDR_W < 9 || ADDR_W > 24) begin : g_bad_addr
      $error("ADDR_W must lie in 9..24");
   end
   if (NUM_PORTS < 1 || NUM_PORTS > MAX_PORTS) begin : g_bad_ports
      $error("NUM_PORTS does not fit the address space");
   end
   if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must lie in 1..4");
   end

   logic [NUM_PORTS-1:0] pb_hit, lb_hit;
   gpio_sel_e            pb_sel, lb_sel;
   gpio_op_e             pb_op,  lb_op;
   logic                 pb_wr,  lb_wr;
   logic                 pb_rd,  lb_rd;
   logic [TOTAL_W-1:0]   pin_sync;

   gpio_bus_decode #(.ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS)) u_pb_dec (
      .valid(pb_valid), .write(pb_write), .addr(pb_addr),
      .port_hit(pb_hit), .sel(pb_sel), .op(pb_op), .wr_en(pb_wr), .rd_en(pb_rd)
   );

   gpio_bus_decode #(.ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS)) u_lb_dec (
      .valid(lb_valid), .write(lb_write), .addr(lb_addr),
      .port_hit(lb_hit), .sel(lb_sel), .op(lb_op), .wr_en(lb_wr), .rd_en(lb_rd)
   );

   gpio_pin_sync #(.W(TOTAL_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .d(pin_in), .q(pin_sync)
   );

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic pb_oe_en, lb_oe_en, pb_out_en, lb_out_en;

      assign pb_oe_en  = pb_wr && pb_hit[p] && (pb_sel == SEL_OE);
      assign lb_oe_en  = lb_wr && lb_hit[p] && (lb_sel == SEL_OE);
      assign pb_out_en = pb_wr && pb_hit[p] && (pb_sel == SEL_OUT);
      assign lb_out_en = lb_wr && lb_hit[p] && (lb_sel == SEL_OUT);

      gpio_port_reg #(.W(PORT_W)) u_oe (
         .clk(clk), .rst(rst),
         .pb_en(pb_oe_en), .pb_op(pb_op), .pb_data(pb_wdata),
         .lb_en(lb_oe_en), .lb_op(lb_op), .lb_data(lb_wdata),
         .q(pin_oe[p*PORT_W +: PORT_W])
      );

      gpio_port_reg #(.W(PORT_W)) u_out (
         .clk(clk), .rst(rst),
         .pb_en(pb_out_en), .pb_op(pb_op), .pb_data(pb_wdata),
         .lb_en(lb_out_en), .lb_op(lb_op), .lb_data(lb_wdata),
         .q(pin_out[p*PORT_W +: PORT_W])
      );
   end

   gpio_read_port #(.NUM_PORTS(NUM_PORTS), .W(PORT_W)) u_pb_rd (
      .clk(clk), .rst(rst), .rd_en(pb_rd), .port_hit(pb_hit), .sel(pb_sel),
      .pin_vals(pin_sync), .rdata(pb_rdata)
   );

   gpio_read_port #(.NUM_PORTS(NUM_PORTS), .W(PORT_W)) u_lb_rd (
      .clk(clk), .rst(rst), .rd_en(lb_rd), .port_hit(lb_hit), .sel(lb_sel),
      .pin_vals(pin_sync), .rdata(lb_rdata)
   );

endmodule

// File: rtl/gpio_dual_bus_chk.sv
module gpio_dual_bus_chk #(
   parameter int NUM_PORTS   = 2,
   parameter int PORT_W      = 32,
   parameter int ADDR_W      = 12,
   parameter int SYNC_STAGES = 2
) (
   input logic                        clk,
   input logic                        rst,
   input logic                        pb_valid,
   input logic                        pb_write,
   input logic [ADDR_W-1:0]           pb_addr,
   input logic [PORT_W-1:0]           pb_rdata,
   input logic                        lb_valid,
   input logic                        lb_write,
   input logic [ADDR_W-1:0]           lb_addr,
   input logic [PORT_W-1:0]           lb_wdata,
   input logic [PORT_W-1:0]           lb_rdata,
   input logic [NUM_PORTS*PORT_W-1:0] pin_oe,
   input logic [NUM_PORTS*PORT_W-1:0] pin_out
);
   logic pb_wr, lb_wr;
   assign pb_wr = pb_valid && pb_write;
   assign lb_wr = lb_valid && lb_write;

   AST_PB_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
      !(pb_valid && !pb_write) |=> pb_rdata == '0);                          // R7
   AST_LB_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
      !(lb_valid && !lb_write) |=> lb_rdata == '0);                          // R7
   AST_DRIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!pb_wr && !lb_wr) |=> ($stable(pin_oe) && $stable(pin_out)));         // R5
   AST_SET_BITS: assert property (@(posedge clk) disable iff (rst)
      (lb_wr && lb_addr == ADDR_W'('h54) && !pb_wr)
      |=> ((pin_out[PORT_W-1:0] & $past(lb_wdata)) == $past(lb_wdata)));     // R4
   AST_CLEAR_BITS: assert property (@(posedge clk) disable iff (rst)
      (lb_wr && lb_addr == ADDR_W'('h58) && !pb_wr)
      |=> ((pin_out[PORT_W-1:0] & $past(lb_wdata)) == '0));                  // R4
   AST_LOCAL_WINS: assert property (@(posedge clk) disable iff (rst)
      (lb_wr && pb_wr && lb_addr == ADDR_W'('h50) && pb_addr == ADDR_W'('h50))
      |=> (pin_out[PORT_W-1:0] == $past(lb_wdata)));                         // R9
   AST_PIN_WORD_RO: assert property (@(posedge clk) disable iff (rst)
      (lb_wr && lb_addr == ADDR_W'('h60) && !pb_wr)
      |=> ($stable(pin_oe) && $stable(pin_out)));                            // R8

endmodule

bind gpio_dual_bus gpio_dual_bus_chk #(
   .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (.*);

// File: tb/gpio_dual_bus_bench.sv
module gpio_dual_bus_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 2;
   localparam int W  = 32;
   localparam int AW = 12;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          pb_valid = 0, pb_write = 0, lb_valid = 0, lb_write = 0;
   logic [AW-1:0] pb_addr = '0, lb_addr = '0;
   logic [W-1:0]  pb_wdata = '0, lb_wdata = '0;
   logic [W-1:0]  pb_rdata, lb_rdata;
   logic [NP*W-1:0] pin_in = '0;
   logic [NP*W-1:0] pin_oe, pin_out;

   int  checks = 0;
   int  errors = 0;
   bit  done = 0;

   logic [W-1:0]    m_oe [NP];
   logic [W-1:0]    m_out[NP];
   logic [NP*W-1:0] m_s1, m_s2;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_dual_bus u_gpio_dual_bus (
      .clk(clk), .rst(rst),
      .pb_valid(pb_valid), .pb_write(pb_write), .pb_addr(pb_addr),
      .pb_wdata(pb_wdata), .pb_rdata(pb_rdata),
      .lb_valid(lb_valid), .lb_write(lb_write), .lb_addr(lb_addr),
      .lb_wdata(lb_wdata), .lb_rdata(lb_rdata),
      .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [NP*W-1:0] act, input logic [NP*W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // kind: 0 none, 1 enable word, 2 value word, 3 pin word
   function automatic void decode(input logic [AW-1:0] a, output int port,
                                  output int kind, output int op);
      port = int'(a[AW-1:8]);
      op   = int'(a[3:2]);
      kind = 0;
      if (a[1:0] == 2'b00 && port < NP) begin
         if (a[7:4] == 4'h4)                       kind = 1;
         else if (a[7:4] == 4'h5)                  kind = 2;
         else if (a[7:0] == 8'h60)                 kind = 3;
      end
   endfunction

   function automatic logic [W-1:0] upd(input int op, input logic [W-1:0] c,
                                        input logic [W-1:0] d);
      case (op)
         0:       return d;
         1:       return c | d;
         2:       return c & ~d;
         default: return c ^ d;
      endcase
   endfunction

   function automatic void model_write(input logic v, input logic wr,
                                       input logic [AW-1:0] a, input logic [W-1:0] d);
      int port, kind, op;
      decode(a, port, kind, op);
      if (v && wr) begin
         if (kind == 1) m_oe[port]  = upd(op, m_oe[port], d);
         if (kind == 2) m_out[port] = upd(op, m_out[port], d);
      end
   endfunction

   function automatic logic [W-1:0] model_read(input logic v, input logic wr,
                                               input logic [AW-1:0] a);
      int port, kind, op;
      decode(a, port, kind, op);
      if (v && !wr && kind == 3) return m_s2[port*W +: W];
      return '0;
   endfunction

   function automatic logic [NP*W-1:0] flat_oe();
      logic [NP*W-1:0] r;
      for (int p = 0; p < NP; p++) r[p*W +: W] = m_oe[p];
      return r;
   endfunction

   function automatic logic [NP*W-1:0] flat_out();
      logic [NP*W-1:0] r;
      for (int p = 0; p < NP; p++) r[p*W +: W] = m_out[p];
      return r;
   endfunction

   // one bus cycle; called at a falling edge, returns at the next falling edge
   task automatic step(input logic pv, input logic pw, input logic [AW-1:0] pa,
                       input logic [W-1:0] pd, input logic lv, input logic lw,
                       input logic [AW-1:0] la, input logic [W-1:0] ld, input string tag);
      logic [W-1:0] e_pb, e_lb;
      pb_valid = pv; pb_write = pw; pb_addr = pa; pb_wdata = pd;
      lb_valid = lv; lb_write = lw; lb_addr = la; lb_wdata = ld;
      e_pb = model_read(pv, pw, pa);
      e_lb = model_read(lv, lw, la);
      model_write(pv, pw, pa, pd);
      model_write(lv, lw, la, ld);
      m_s2 = m_s1;
      m_s1 = pin_in;
      @(posedge clk);
      @(negedge clk);
      check(pin_oe == flat_oe(), tag, "pin_oe", pin_oe, flat_oe());
      check(pin_out == flat_out(), tag, "pin_out", pin_out, flat_out());
      check(pb_rdata == e_pb, tag, "pb_rdata", {32'h0, pb_rdata}, {32'h0, e_pb});
      check(lb_rdata == e_lb, tag, "lb_rdata", {32'h0, lb_rdata}, {32'h0, e_lb});
   endtask

   task automatic idle(input string tag);
      step(0, 0, '0, '0, 0, 0, '0, '0, tag);
   endtask

   function automatic logic [AW-1:0] rand_addr();
      logic [3:0] port;
      logic [7:0] off;
      int k;
      port = 4'($urandom % 3);
      k = int'($urandom % 12);
      if (k < 8)       off = 8'h40 + 8'(4 * k);
      else if (k == 8) off = 8'h60;
      else if (k == 9) off = 8'h64;
      else if (k == 10) off = 8'h70;
      else             off = 8'h51;
      return {port, off};
   endfunction

   initial begin
      void'($urandom(32'd4242));
      for (int p = 0; p < NP; p++) begin m_oe[p] = '0; m_out[p] = '0; end
      m_s1 = '0; m_s2 = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: state during reset
      check(pin_oe == '0 && pin_out == '0, "R1", "drive in reset", {pin_oe[31:0], pin_out[31:0]}, '0);
      check(pb_rdata == '0 && lb_rdata == '0, "R1", "rdata in reset", {pb_rdata, lb_rdata}, '0);
      rst = 1'b0;
      idle("R1");

      // R3: replace the enable word of port 0 from the local bus
      step(0, 0, '0, '0, 1, 1, 12'h040, 32'hA5A5_0F0F, "R3");
      check(pin_oe[31:0] == 32'hA5A5_0F0F, "R3", "oe replace", pin_oe, 64'hA5A5_0F0F);
      // R4: set, clear, toggle of the value word
      step(1, 1, 12'h054, 32'h0000_00FF, 0, 0, '0, '0, "R4");
      step(0, 0, '0, '0, 1, 1, 12'h058, 32'h0000_000F, "R4");
      step(1, 1, 12'h05C, 32'h8000_0011, 0, 0, '0, '0, "R4");
      check(pin_out[31:0] == 32'h8000_00E1, "R4", "set/clear/toggle", pin_out, 64'h8000_00E1);
      // R2: port 1 at 0x140
      step(1, 1, 12'h140, 32'h1234_5678, 0, 0, '0, '0, "R2");
      check(pin_oe[63:32] == 32'h1234_5678, "R2", "port1 oe", pin_oe, {32'h1234_5678, 32'hA5A5_0F0F});
      // R8: ignored writes
      step(1, 1, 12'h060, 32'hFFFF_FFFF, 1, 1, 12'h070, 32'hFFFF_FFFF, "R8");
      step(1, 1, 12'h041, 32'hFFFF_FFFF, 1, 1, 12'h250, 32'hFFFF_FFFF, "R8");
      step(0, 0, '0, '0, 1, 1, 12'h164, 32'hFFFF_FFFF, "R8");
      check(pin_out[31:0] == 32'h8000_00E1 && pin_oe[31:0] == 32'hA5A5_0F0F, "R8",
            "ignored writes", {pin_oe[31:0], pin_out[31:0]}, {32'hA5A5_0F0F, 32'h8000_00E1});
      // R9: same word from both buses
      step(1, 1, 12'h050, 32'h1111_1111, 1, 1, 12'h050, 32'h2222_2222, "R9");
      check(pin_out[31:0] == 32'h2222_2222, "R9", "local wins", pin_out, 64'h2222_2222);
      step(1, 1, 12'h054, 32'h0000_F000, 1, 1, 12'h058, 32'h0000_3000, "R9");
      check(pin_out[31:0] == 32'h2222_C222, "R9", "set then clear", pin_out, 64'h2222_C222);
      // R10: different words in one cycle
      step(1, 1, 12'h148, 32'h0000_0078, 1, 1, 12'h15C, 32'hFFFF_0000, "R10");
      check(pin_oe[63:32] == 32'h1234_5600 && pin_out[63:32] == 32'hFFFF_0000, "R10",
            "parallel writes", {pin_oe[63:32], pin_out[63:32]}, {32'h1234_5600, 32'hFFFF_0000});
      // R11: back-to-back local toggles
      for (int i = 0; i < 4; i++)
         step(0, 0, '0, '0, 1, 1, 12'h05C, 32'h1 << i, "R11");
      check(pin_out[3:0] == 4'hD, "R11", "toggle burst", {60'h0, pin_out[3:0]}, 64'hD);
      // R6: pin latency
      pin_in = 64'hDEAD_BEEF_CAFE_F00D;
      step(0, 0, '0, '0, 1, 0, 12'h060, '0, "R6");
      step(1, 0, 12'h160, '0, 1, 0, 12'h060, '0, "R6");
      step(1, 0, 12'h160, '0, 1, 0, 12'h060, '0, "R6");
      check(lb_rdata == 32'hCAFE_F00D && pb_rdata == 32'hDEAD_BEEF, "R6", "pin read",
            {pb_rdata, lb_rdata}, 64'hDEAD_BEEF_CAFE_F00D);
      // R7: reads of write-only and unmapped addresses
      step(1, 0, 12'h050, '0, 1, 0, 12'h260, '0, "R7");
      step(1, 0, 12'h061, '0, 1, 0, 12'h044, '0, "R7");
      idle("R7");

      // R10: random traffic on both buses
      for (int n = 0; n < 3000; n++) begin
         logic [AW-1:0] pa, la;
         pa = rand_addr();
         la = ($urandom % 4 == 0) ? pa : rand_addr();
         if (n % 40 == 0) pin_in = {$urandom, $urandom};
         step(1'($urandom), 1'($urandom), pa, $urandom,
              1'($urandom), 1'($urandom), la, $urandom, "R10");
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule